// File: doc/BRIEF.md
# Prioritized Two-Level Interrupt Controller

This block gathers interrupt request lines from peripherals and presents two requests to a processor: a normal request (`irq_o`) and a fast request (`fiq_o`). It has two banks of 32 sources each. The second bank drives one fixed input of the first bank through its own normal-request output, so the first bank can report "the second bank wants service". A global interrupt number is the bank index times 32 plus the source index, and the source index is the low five bits of that number.

Every source has a small level register. The register sets the source's priority, chooses between edge and level sensing, and says whether the source goes to the fast output. Only the first bank honours the fast-output bit. Among the requests that are pending and not masked, the arbiter picks a winner. It then latches that winner and keeps it until software acknowledges it through the control register. Software reads a source-number register to find which source won.

Every access goes through one word-wide read/write port. Reads return data one cycle after the address is presented. In the byte address, bit 8 selects the bank and bits 7:0 select the register inside it.

Top module: `irqc_cascade`

## Requirements
- R1: After reset, both mask registers read 0xFFFF_FFFF, all level registers read 0, both source-number registers read 0, and `irq_o` and `fiq_o` are low.
- R2: Among pending, unmasked sources that are not steered to the fast output, the normal winner is the one with the smallest priority value. On a tie, the lower source index wins.
- R3: Once a winner is latched, it stays in the source-number register, and its output stays high, even when a more urgent source arrives. This holds until the winner is acknowledged.
- R4: Writing control (byte offset 0x10) with bit 0 set drops `irq_o` in the cycle after the write. Arbitration then restarts one cycle later. The acknowledge also clears the latched edge of the acknowledged source.
- R5: A first-bank source whose level bit 0 is 1 competes only for `fiq_o`. Its number appears in the fast source-number register at offset 0x0C. Control bit 1 acknowledges it, and `fiq_o` drops in the cycle after that write.
- R6: In the second bank, level bit 0 always reads 0, and no second-bank source can raise `fiq_o`.
- R7: Level bit 1 set makes a source edge-sensed: a rising edge sets its pending bit (offset 0x00), and the bit stays set after the line falls. With bit 1 clear, the pending bit follows the line.
- R8: A set bit in the mask register (offset 0x04) keeps that source from winning, while its pending bit still records requests.
- R9: Writing the pending register clears every latched edge whose written bit is 0. If such a source is unmasked afterwards, no request results.
- R10: The second bank's normal request feeds first-bank source 0. When that source wins, the first bank reports index 0 and the second bank reports its own winner. Retiring the request takes an acknowledge in the second bank and then one in the first bank.
- R11: Each source-number register holds a valid flag in bit 31 and the winning index in bits 4:0. It reads 0 when there is no winner.
- R12: Source i's level register sits at byte offset 0x80 + 4*i. Its priority is in bits 6:2, its edge select in bit 1 and its fast-output steer in bit 0. Byte-address bit 8 selects the second bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_src | input | 32 | First-bank request lines; bit 0 is ORed with the second bank's request |
| l2_src | input | 32 | Second-bank request lines |
| bus_wr | input | 1 | Write strobe; takes effect only on word-aligned addresses |
| bus_addr | input | 9 | Byte address; bit 8 selects the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after the address |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that software acknowledges only by writing the control register. They also assume the mask bits an assertion inspects come from register writes, not from requests that change inside a cycle, and that requests may rise and fall at any cycle boundary. The stimulus meets these assumptions in three ways. It changes every input at the falling clock edge. It lowers each level request one cycle before acknowledging it. In the cascade, it acknowledges the second bank before the first, so that the first bank does not re-latch a request that is already being retired.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int PRIO_W = 5;

  // word offsets inside one bank (lower half of the bank window)
  localparam int WOFS_PEND = 0;
  localparam int WOFS_MASK = 1;
  localparam int WOFS_IRQN = 2;
  localparam int WOFS_FIQN = 3;
  localparam int WOFS_CTRL = 4;

  // control bits
  localparam int CTRL_ACK_IRQ = 0;
  localparam int CTRL_ACK_FIQ = 1;

  typedef struct packed {
    logic [PRIO_W-1:0] prio;      // bits 6:2
    logic              trig_edge; // bit 1
    logic              to_fiq;    // bit 0
  } irqc_lvl_t;

  localparam int LVL_W = $bits(irqc_lvl_t);
endpackage

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] line,
  input  logic [NSRC-1:0] edge_sel,
  input  logic            keep_wr,
  input  logic [NSRC-1:0] keep_bits,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] line_q;
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] latch_q;
  logic [NSRC-1:0] keep_mask;
  logic [NSRC-1:0] rise;

  assign keep_mask = keep_wr ? keep_bits : '1;
  assign rise      = line & ~prev_q & edge_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q  <= '0;
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      line_q  <= line;
      prev_q  <= line;
      latch_q <= ((latch_q & ~ack_clr & keep_mask) | rise) & edge_sel;
    end
  end

  assign pend = (latch_q & edge_sel) | (line_q & ~edge_sel);
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
  parameter int NSRC   = 32,
  parameter int PRIO_W = 5,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             cand,
  input  logic [NSRC-1:0][PRIO_W-1:0] prio,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);
  logic [PRIO_W-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < NSRC; i++) begin
      if (cand[i] && (!found || prio[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
  import irqc_pkg::*;
#(
  parameter int  NSRC    = 32,
  parameter int  DATA_W  = 32,
  parameter bit  HAS_FIQ = 1'b1,
  localparam int IDX_W   = $clog2(NSRC),
  localparam int WA_W    = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   line,
  input  logic              wr_en,
  input  logic [WA_W-1:0]   waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [WA_W-1:0]   raddr,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  irqc_lvl_t           lvl_q [NSRC];
  logic [NSRC-1:0]     mask_q;
  logic                irq_v_q, fiq_v_q;
  logic [IDX_W-1:0]    irq_idx_q, fiq_idx_q;

  logic [NSRC-1:0]             edge_sel, fiq_sel, pend, ack_clr, live;
  logic [NSRC-1:0][PRIO_W-1:0] prio_v;
  logic                        ack_irq, ack_fiq, pend_wr, mask_wr;
  logic                        irq_found, fiq_found;
  logic [IDX_W-1:0]            irq_pick, fiq_pick;

  assign ack_irq = wr_en && (waddr == WA_W'(WOFS_CTRL)) && wdata[CTRL_ACK_IRQ];
  assign ack_fiq = wr_en && (waddr == WA_W'(WOFS_CTRL)) && wdata[CTRL_ACK_FIQ];
  assign pend_wr = wr_en && (waddr == WA_W'(WOFS_PEND));
  assign mask_wr = wr_en && (waddr == WA_W'(WOFS_MASK));

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      edge_sel[i] = lvl_q[i].trig_edge;
      fiq_sel[i]  = lvl_q[i].to_fiq;
      prio_v[i]   = lvl_q[i].prio;
    end
  end

  assign ack_clr = ((ack_irq && irq_v_q) ? (NSRC'(1) << irq_idx_q) : '0)
                 | ((ack_fiq && fiq_v_q) ? (NSRC'(1) << fiq_idx_q) : '0);

  irqc_pend #(.NSRC(NSRC)) i_pend (
    .clk      (clk),
    .rst      (rst),
    .line     (line),
    .edge_sel (edge_sel),
    .keep_wr  (pend_wr),
    .keep_bits(wdata[NSRC-1:0]),
    .ack_clr  (ack_clr),
    .pend     (pend)
  );

  assign live = pend & ~mask_q;

  irqc_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_pick_irq (
    .cand (live & ~fiq_sel),
    .prio (prio_v),
    .found(irq_found),
    .idx  (irq_pick)
  );

  generate
    if (HAS_FIQ) begin : g_fiq
      irqc_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) i_pick_fiq (
        .cand (live & fiq_sel),
        .prio (prio_v),
        .found(fiq_found),
        .idx  (fiq_pick)
      );
    end else begin : g_nofiq
      assign fiq_found = 1'b0;
      assign fiq_pick  = '0;
    end
  endgenerate

  // level registers and mask
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      for (int i = 0; i < NSRC; i++) lvl_q[i] <= '0;
    end else begin
      if (mask_wr) mask_q <= wdata[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (wr_en && waddr == WA_W'((1 << IDX_W) + i)) begin
          lvl_q[i].prio      <= wdata[LVL_W-1:2];
          lvl_q[i].trig_edge <= wdata[1];
          lvl_q[i].to_fiq    <= HAS_FIQ ? wdata[0] : 1'b0;
        end
      end
    end
  end

  // latched arbitration, one path per output
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_v_q   <= 1'b0;
      irq_idx_q <= '0;
      fiq_v_q   <= 1'b0;
      fiq_idx_q <= '0;
    end else begin
      if (ack_irq) begin
        irq_v_q <= 1'b0;
      end else if (!irq_v_q && irq_found) begin
        irq_v_q   <= 1'b1;
        irq_idx_q <= irq_pick;
      end
      if (ack_fiq) begin
        fiq_v_q <= 1'b0;
      end else if (!fiq_v_q && fiq_found) begin
        fiq_v_q   <= 1'b1;
        fiq_idx_q <= fiq_pick;
      end
    end
  end

  assign irq_o = irq_v_q;
  assign fiq_o = fiq_v_q;

  always_comb begin
    rdata = '0;
    if (raddr[IDX_W]) begin
      rdata = DATA_W'(lvl_q[raddr[IDX_W-1:0]]);
    end else begin
      case (raddr)
        WA_W'(WOFS_PEND): rdata = DATA_W'(pend);
        WA_W'(WOFS_MASK): rdata = DATA_W'(mask_q);
        WA_W'(WOFS_IRQN): rdata = irq_v_q ? ((DATA_W'(1) << (DATA_W-1)) | DATA_W'(irq_idx_q)) : '0;
        WA_W'(WOFS_FIQN): rdata = fiq_v_q ? ((DATA_W'(1) << (DATA_W-1)) | DATA_W'(fiq_idx_q)) : '0;
        default:          rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irqc_cascade.sv
module irqc_cascade #(
  parameter int  NSRC     = 32,
  parameter int  DATA_W   = 32,
  parameter int  CASC_SRC = 0,
  localparam int IDX_W    = $clog2(NSRC),
  localparam int WA_W     = IDX_W + 1,
  localparam int ADDR_W   = WA_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   l1_src,
  input  logic [NSRC-1:0]   l2_src,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  logic              aligned, bank_sel;
  logic [WA_W-1:0]   word;
  logic [NSRC-1:0]   l1_line;
  logic              l1_irq, l1_fiq, l2_irq, l2_fiq;
  logic [DATA_W-1:0] l1_rd, l2_rd, rdata_q;

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign bank_sel = bus_addr[ADDR_W-1];
  assign word     = bus_addr[ADDR_W-2:2];
  assign l1_line  = l1_src | (NSRC'(l2_irq) << CASC_SRC);

  irqc_bank #(.NSRC(NSRC), .DATA_W(DATA_W), .HAS_FIQ(1'b1)) i_l1 (
    .clk  (clk),
    .rst  (rst),
    .line (l1_line),
    .wr_en(bus_wr && aligned && !bank_sel),
    .waddr(word),
    .wdata(bus_wdata),
    .raddr(word),
    .rdata(l1_rd),
    .irq_o(l1_irq),
    .fiq_o(l1_fiq)
  );

  irqc_bank #(.NSRC(NSRC), .DATA_W(DATA_W), .HAS_FIQ(1'b0)) i_l2 (
    .clk  (clk),
    .rst  (rst),
    .line (l2_src),
    .wr_en(bus_wr && aligned && bank_sel),
    .waddr(word),
    .wdata(bus_wdata),
    .raddr(word),
    .rdata(l2_rd),
    .irq_o(l2_irq),
    .fiq_o(l2_fiq)
  );

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= bank_sel ? l2_rd : l1_rd;
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = l1_irq;
  assign fiq_o     = l1_fiq | l2_fiq;
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
  parameter int  NSRC   = 32,
  parameter int  DATA_W = 32,
  localparam int IDX_W  = $clog2(NSRC),
  localparam int ADDR_W = IDX_W + 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              irq_o,
  input logic              fiq_o,
  input logic [IDX_W-1:0]  l1_irq_idx,
  input logic [NSRC-1:0]   l1_mask
);
  logic            ctrl_l1, ack_irq, ack_fiq;
  logic [NSRC-1:0] mask_d;

  assign ctrl_l1 = bus_wr && (bus_addr == ADDR_W'(irqc_pkg::WOFS_CTRL * 4));
  assign ack_irq = ctrl_l1 && bus_wdata[irqc_pkg::CTRL_ACK_IRQ];
  assign ack_fiq = ctrl_l1 && bus_wdata[irqc_pkg::CTRL_ACK_FIQ];

  always_ff @(posedge clk) begin
    if (rst) mask_d <= '1;
    else     mask_d <= l1_mask;
  end

  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !fiq_o));

  p_winner_held_r3: assert property (@(posedge clk) disable iff (rst)
    (irq_o && !ack_irq) |=> (irq_o && $stable(l1_irq_idx)));

  p_irq_ack_drop_r4: assert property (@(posedge clk) disable iff (rst)
    ack_irq |=> !irq_o);

  p_fiq_ack_drop_r5: assert property (@(posedge clk) disable iff (rst)
    ack_fiq |=> !fiq_o);

  p_winner_unmasked_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> !mask_d[l1_irq_idx]);
endmodule

bind irqc_cascade irqc_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .irq_o     (irq_o),
  .fiq_o     (fiq_o),
  .l1_irq_idx(i_l1.irq_idx_q),
  .l1_mask   (i_l1.mask_q)
);

// File: tb/test_irqc_cascade.sv
`timescale 1ns/1ps
module test_irqc_cascade;
  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] l1_src, l2_src;
  logic        bus_wr;
  logic [8:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, fiq_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqc_cascade i_irqc_cascade (
    .clk(clk), .rst(rst), .l1_src(l1_src), .l2_src(l2_src),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  localparam int NV = 7;
  localparam logic [31:0] V_LINE [NV] = '{
    32'h0000_0220, 32'h0010_0200, 32'h8010_0000, 32'h8010_0000,
    32'h0000_0018, 32'h0000_0080, 32'h0000_0000};
  localparam logic [31:0] V_MASK [NV] = '{
    32'h0, 32'h0, 32'h0, 32'h8000_0000, 32'h0, 32'h0000_0080, 32'h0};
  localparam logic [31:0] V_EXP  [NV] = '{
    32'h8000_0005, 32'h8000_0014, 32'h8000_001F, 32'h8000_0014,
    32'h8000_0003, 32'h0, 32'h0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; l1_src = '0; l2_src = '0;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    idle(3);
    rst = 1'b0;

    // R1 reset state
    check("R1 irq_o", {31'b0, irq_o}, 32'h0);
    check("R1 fiq_o", {31'b0, fiq_o}, 32'h0);
    rd(9'h004, d); check("R1 l1 mask", d, 32'hFFFF_FFFF);
    rd(9'h104, d); check("R1 l2 mask", d, 32'hFFFF_FFFF);
    rd(9'h008, d); check("R1 irq num", d, 32'h0);
    rd(9'h00C, d); check("R1 fiq num", d, 32'h0);
    rd(9'h094, d); check("R1 level reg", d, 32'h0);

    // R12 level register placement and layout
    wr(9'h094, 32'h0000_000D);
    rd(9'h094, d); check("R12 level readback", d, 32'h0000_000D);

    // priorities: all 16, then a few specials
    for (int i = 0; i < 32; i++) wr(9'(9'h080 + 4 * i), 32'h40);
    wr(9'h094, 32'h0C);   // src 5 prio 3
    wr(9'h0A4, 32'h0C);   // src 9 prio 3
    wr(9'h0D0, 32'h04);   // src 20 prio 1
    wr(9'h0FC, 32'h00);   // src 31 prio 0

    // table walk: R2, R8, R11
    for (int v = 0; v < NV; v++) begin
      wr(9'h004, V_MASK[v]);
      @(negedge clk); l1_src = V_LINE[v];
      idle(4);
      check($sformatf("R2 vec%0d irq_o", v), {31'b0, irq_o}, {31'b0, V_EXP[v][31]});
      rd(9'h008, d);
      check($sformatf("R11 vec%0d irq num", v), d, V_EXP[v]);
      @(negedge clk); l1_src = '0;
      idle(1);
      wr(9'h010, 32'h1);
      idle(3);
    end
    wr(9'h004, 32'h0);

    // R3 hold and R4 acknowledge timing
    @(negedge clk); l1_src = 32'h0000_0200;
    idle(4);
    rd(9'h008, d); check("R3 first winner", d, 32'h8000_0009);
    @(negedge clk); l1_src = 32'h8000_0200;
    idle(4);
    rd(9'h008, d); check("R3 winner held", d, 32'h8000_0009);
    @(negedge clk); l1_src = 32'h8000_0000;
    idle(1);
    wr(9'h010, 32'h1);
    check("R4 irq_o drops", {31'b0, irq_o}, 32'h0);
    idle(1);
    check("R4 re-arbitrated", {31'b0, irq_o}, 32'h1);
    rd(9'h008, d); check("R4 next winner", d, 32'h8000_001F);
    @(negedge clk); l1_src = '0;
    idle(1);
    wr(9'h010, 32'h1);
    idle(3);

    // R7 edge sensing
    wr(9'h0B0, 32'h0A);   // src 12 prio 2, edge
    @(negedge clk); l1_src = 32'h0000_1000;
    @(negedge clk); l1_src = '0;
    idle(4);
    rd(9'h008, d); check("R7 edge winner", d, 32'h8000_000C);
    rd(9'h000, d); check("R7 edge held", d & 32'h1000, 32'h1000);
    wr(9'h010, 32'h1);
    idle(3);
    check("R4 edge acked irq_o", {31'b0, irq_o}, 32'h0);
    rd(9'h000, d); check("R4 edge cleared", d & 32'h1000, 32'h0);
    // R7 level follows line
    @(negedge clk); l1_src = 32'h0000_0008;
    idle(2);
    rd(9'h000, d); check("R7 level high", d & 32'h8, 32'h8);
    @(negedge clk); l1_src = '0;
    idle(2);
    rd(9'h000, d); check("R7 level low", d & 32'h8, 32'h0);
    wr(9'h010, 32'h1);
    idle(3);

    // R8 / R9 masked edge, then cleared by pending write
    wr(9'h004, 32'h0000_1000);
    @(negedge clk); l1_src = 32'h0000_1000;
    @(negedge clk); l1_src = '0;
    idle(3);
    check("R8 masked no irq", {31'b0, irq_o}, 32'h0);
    rd(9'h000, d); check("R8 masked still pending", d & 32'h1000, 32'h1000);
    wr(9'h000, 32'h0);
    rd(9'h000, d); check("R9 pending cleared", d & 32'h1000, 32'h0);
    wr(9'h004, 32'h0);
    idle(4);
    check("R9 no request after unmask", {31'b0, irq_o}, 32'h0);

    // R5 fast output
    wr(9'h098, 32'h01);   // src 6 to fast output, prio 0
    @(negedge clk); l1_src = 32'h0000_0040;
    idle(4);
    check("R5 fiq_o", {31'b0, fiq_o}, 32'h1);
    check("R5 irq_o stays low", {31'b0, irq_o}, 32'h0);
    rd(9'h00C, d); check("R5 fiq num", d, 32'h8000_0006);
    @(negedge clk); l1_src = '0;
    idle(1);
    wr(9'h010, 32'h2);
    check("R5 fiq_o drops", {31'b0, fiq_o}, 32'h0);
    idle(3);
    check("R5 fiq stays low", {31'b0, fiq_o}, 32'h0);

    // R6 / R10 second bank through cascade
    wr(9'h190, 32'h01);
    rd(9'h190, d); check("R6 l2 fast bit forced", d, 32'h0);
    wr(9'h104, 32'hFFFF_FFEF);
    @(negedge clk); l2_src = 32'h0000_0010;
    idle(6);
    rd(9'h108, d); check("R10 l2 irq num", d, 32'h8000_0004);
    rd(9'h008, d); check("R10 l1 reports cascade", d, 32'h8000_0000);
    check("R10 irq_o", {31'b0, irq_o}, 32'h1);
    check("R6 no fiq from l2", {31'b0, fiq_o}, 32'h0);
    @(negedge clk); l2_src = '0;
    wr(9'h110, 32'h1);
    wr(9'h010, 32'h1);
    idle(4);
    check("R10 retired", {31'b0, irq_o}, 32'h0);
    rd(9'h108, d); check("R10 l2 num cleared", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule